// File: doc/BRIEF.md
# Double-Precision Funnel Right Shifter

This block shifts a destination operand right by a count and fills the vacated upper bit positions from the low end of a second source operand. The operation is the building block of multi-word right shifts: a wide value held across several registers is shifted one word at a time, and each step pulls in the bits that fall off the next higher word. The operand size is 16, 32 or 64 bits. The raw count byte is reduced by a size-dependent mask before use.

Besides the shifted result, the block produces carry, overflow, sign, zero and parity flags. Each flag has its own update-enable, so the surrounding pipeline knows which flags to commit. A zero count leaves the operand and every flag untouched. A count larger than the operand size, which only the 16-bit size can produce, has no architected result. In that case the block raises an undefined indicator and returns the destination unchanged, with no flag updates. All outputs are registered and appear one clock after the inputs.

Top module: `funnel_shr_unit`

## Requirements
- R1: `size_i` selects the operand width W: 2'b00 is 16 bits, 2'b01 is 32 bits, 2'b10 and 2'b11 are 64 bits. The effective count c is `cnt_i[4:0]` for W of 16 or 32, and `cnt_i[5:0]` for W of 64.
- R2: Every output is registered. It reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.
- R3: For 0 < c <= W, result bit i equals destination bit i+c for i < W-c, and equals source bit i+c-W for W-c <= i < W. Bits of `res_o` at and above W are 0 in every case, and only the low W bits of `dst_i` and `src_i` are used.
- R4: When c is 0, `res_o` equals the low W bits of `dst_i`, `upd_o` is 0 and `undef_o` is 0.
- R5: For 0 < c <= W, `cf_o` equals destination bit c-1 and `upd_o[0]` (carry update) is 1.
- R6: For c equal to 1, `of_o` is the XOR of result bit W-1 and destination bit W-1, and `upd_o[1]` is 1. For any other count, `of_o` is 0 and `upd_o[1]` is 0.
- R7: For 0 < c <= W, `sf_o` is result bit W-1, `zf_o` is 1 when the W-bit result is all zeros, and `pf_o` is 1 when result bits 7:0 hold an even number of ones. Their update bits `upd_o[2]`, `upd_o[3]` and `upd_o[4]` are 1.
- R8: When W is 16 and c is 17 to 31, `undef_o` is 1, `res_o` equals the low 16 bits of `dst_i`, and `upd_o` is 0.
- R9: Every flag output whose update bit in `upd_o` is 0 is driven to 0.
- R10: When c equals W, `res_o` equals the low W bits of `src_i` and `cf_o` equals destination bit W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_i | input | 64 | Operand to be shifted right |
| src_i | input | 64 | Operand whose low bits fill the vacated upper positions |
| cnt_i | input | 8 | Raw shift count before masking |
| size_i | input | 2 | Operand width select |
| res_o | output | 64 | Shifted result, zero above the operand width |
| cf_o | output | 1 | Carry flag, last bit shifted out |
| of_o | output | 1 | Overflow flag, sign change on a one-bit shift |
| sf_o | output | 1 | Sign flag of the result |
| zf_o | output | 1 | Zero flag of the result |
| pf_o | output | 1 | Even parity of the result's low byte |
| upd_o | output | 5 | Flag update-enables: bit 0 carry, 1 overflow, 2 sign, 3 zero, 4 parity |
| undef_o | output | 1 | Count exceeds operand width; result is the unmodified destination |

## Verification
The checker assumes that the inputs are stable during the active clock edge and that any input value, including a size code of 2'b11 and count bits above the mask, is legal. The properties that look at inputs only relate the 16- and 32-bit sizes to the registered outputs, and only on the cycle after a sample taken out of reset. The bench drives all inputs on the falling edge. It sweeps every raw count byte for every size code and then adds random operands with the count drawn either from the full byte or from the range 0 to W+1, so the zero, one, full-width and oversized counts all occur often.

// File: rtl/funnel_shr_pkg.sv
package funnel_shr_pkg;

  localparam int unsigned OPND_W  = 64;
  localparam int unsigned WIDX_W  = 7;
  localparam int unsigned NFLAGS  = 5;

  localparam int unsigned FLG_CF = 0;
  localparam int unsigned FLG_OF = 1;
  localparam int unsigned FLG_SF = 2;
  localparam int unsigned FLG_ZF = 3;
  localparam int unsigned FLG_PF = 4;

  typedef enum logic [1:0] {
    OPSZ_16  = 2'b00,
    OPSZ_32  = 2'b01,
    OPSZ_64  = 2'b10,
    OPSZ_64X = 2'b11
  } opsize_e;

  typedef logic [WIDX_W-1:0] widx_t;

  // Number of operand bits for a size code.
  function automatic widx_t opsize_bits(input opsize_e sz);
    case (sz)
      OPSZ_16: return widx_t'(16);
      OPSZ_32: return widx_t'(32);
      default: return widx_t'(64);
    endcase
  endfunction

  // Low-bit mask of a given width, all ones for a full 64-bit width.
  function automatic logic [OPND_W-1:0] low_mask(input widx_t w);
    logic [OPND_W-1:0] m;
    if (w >= widx_t'(OPND_W)) m = '1;
    else                      m = (OPND_W'(1) << w) - OPND_W'(1);
    return m;
  endfunction

  // Bit at a run-time position, where the position is one below w.
  function automatic logic bit_below(input logic [OPND_W-1:0] v, input widx_t w);
    widx_t idx;
    idx = w - widx_t'(1);
    return v[idx[5:0]];
  endfunction

  // Even parity of the low byte: 1 when it holds an even count of ones.
  function automatic logic even_parity8(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/funnel_cnt_mask.sv
module funnel_cnt_mask
  import funnel_shr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  opsize_e          size_i,
  input  logic [CNT_W-1:0] cnt_i,
  output widx_t            width_o,
  output widx_t            cnt_o,
  output logic             zero_o,
  output logic             undef_o
);

  localparam int unsigned NARROW_BITS = 5;
  localparam int unsigned WIDE_BITS   = 6;

  widx_t cnt_narrow, cnt_wide;

  assign cnt_narrow = widx_t'(cnt_i[NARROW_BITS-1:0]);
  assign cnt_wide   = widx_t'(cnt_i[WIDE_BITS-1:0]);

  always_comb begin
    width_o = opsize_bits(size_i);
    cnt_o   = (width_o == widx_t'(OPND_W)) ? cnt_wide : cnt_narrow;
    zero_o  = (cnt_o == '0);
    undef_o = (cnt_o > width_o);
  end

endmodule

// File: rtl/funnel_core.sv
module funnel_core
  import funnel_shr_pkg::*;
#(
  parameter int unsigned DATA_W = OPND_W
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  widx_t             width_i,
  input  widx_t             cnt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_o,
  output logic              dst_msb_o
);

  localparam int unsigned CAT_W = 2 * DATA_W;

  logic [DATA_W-1:0] wmask, dst_w, src_w;
  logic [CAT_W-1:0]  cat, shifted;
  logic [DATA_W-1:0] cf_tap;

  always_comb begin
    wmask   = low_mask(width_i);
    dst_w   = dst_i & wmask;
    src_w   = src_i & wmask;
    // Place the source directly above the destination, then shift the pair.
    cat     = ({{DATA_W{1'b0}}, src_w} << width_i) | {{DATA_W{1'b0}}, dst_w};
    shifted = cat >> cnt_i;
    res_o   = shifted[DATA_W-1:0] & wmask;
    cf_tap  = dst_w >> (cnt_i - widx_t'(1));
    cf_o    = (cnt_i != '0) & cf_tap[0];
    dst_msb_o = bit_below(dst_w, width_i);
  end

endmodule

// File: rtl/funnel_flags.sv
module funnel_flags
  import funnel_shr_pkg::*;
#(
  parameter int unsigned DATA_W = OPND_W
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] dst_i,
  input  widx_t             width_i,
  input  widx_t             cnt_i,
  input  logic              zero_i,
  input  logic              undef_i,
  input  logic              cf_i,
  input  logic              dst_msb_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic [NFLAGS-1:0] upd_o
);

  logic shift_act, one_bit, res_msb;
  logic [NFLAGS-1:0] raw;

  always_comb begin
    shift_act = ~zero_i & ~undef_i;
    one_bit   = shift_act & (cnt_i == widx_t'(1));
    res_msb   = bit_below(res_i, width_i);

    raw         = '0;
    raw[FLG_CF] = cf_i;
    raw[FLG_OF] = res_msb ^ dst_msb_i;
    raw[FLG_SF] = res_msb;
    raw[FLG_ZF] = (res_i == '0);
    raw[FLG_PF] = even_parity8(res_i[7:0]);
  end

  // One enable per flag; overflow alone depends on the single-bit case.
  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    if (f == FLG_OF) begin : g_of
      assign upd_o[f] = one_bit;
    end else begin : g_std
      assign upd_o[f] = shift_act;
    end
    assign flags_o[f] = raw[f] & upd_o[f];
  end

  logic unused_dst;
  assign unused_dst = ^dst_i;

endmodule

// File: rtl/funnel_shr_unit.sv
module funnel_shr_unit
  import funnel_shr_pkg::*;
#(
  parameter int unsigned DATA_W = OPND_W,
  parameter int unsigned CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  dst_i,
  input  logic [DATA_W-1:0]  src_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [1:0]         size_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               cf_o,
  output logic               of_o,
  output logic               sf_o,
  output logic               zf_o,
  output logic               pf_o,
  output logic [NFLAGS-1:0]  upd_o,
  output logic               undef_o
);

  opsize_e           size_w;
  widx_t             width_w, cnt_w;
  logic              zero_cnt_w, undef_w;
  logic [DATA_W-1:0] shift_res_w, dst_sel_w, next_res_w;
  logic              cf_w, dst_msb_w;
  logic [NFLAGS-1:0] flags_w, upd_w;

  assign size_w = opsize_e'(size_i);

  funnel_cnt_mask #(.CNT_W(CNT_W)) u_mask (
    .size_i  (size_w),
    .cnt_i   (cnt_i),
    .width_o (width_w),
    .cnt_o   (cnt_w),
    .zero_o  (zero_cnt_w),
    .undef_o (undef_w)
  );

  funnel_core #(.DATA_W(DATA_W)) u_core (
    .dst_i     (dst_i),
    .src_i     (src_i),
    .width_i   (width_w),
    .cnt_i     (cnt_w),
    .res_o     (shift_res_w),
    .cf_o      (cf_w),
    .dst_msb_o (dst_msb_w)
  );

  funnel_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i     (shift_res_w),
    .dst_i     (dst_i),
    .width_i   (width_w),
    .cnt_i     (cnt_w),
    .zero_i    (zero_cnt_w),
    .undef_i   (undef_w),
    .cf_i      (cf_w),
    .dst_msb_i (dst_msb_w),
    .flags_o   (flags_w),
    .upd_o     (upd_w)
  );

  assign dst_sel_w  = dst_i & low_mask(width_w);
  assign next_res_w = (zero_cnt_w | undef_w) ? dst_sel_w : shift_res_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      cf_o    <= 1'b0;
      of_o    <= 1'b0;
      sf_o    <= 1'b0;
      zf_o    <= 1'b0;
      pf_o    <= 1'b0;
      upd_o   <= '0;
      undef_o <= 1'b0;
    end else begin
      res_o   <= next_res_w;
      cf_o    <= flags_w[FLG_CF];
      of_o    <= flags_w[FLG_OF];
      sf_o    <= flags_w[FLG_SF];
      zf_o    <= flags_w[FLG_ZF];
      pf_o    <= flags_w[FLG_PF];
      upd_o   <= upd_w;
      undef_o <= undef_w;
    end
  end

endmodule

// File: rtl/funnel_shr_checks.sv
module funnel_shr_checks #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] dst_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] res_o,
  input logic              cf_o,
  input logic              of_o,
  input logic              sf_o,
  input logic              zf_o,
  input logic              pf_o,
  input logic [4:0]        upd_o,
  input logic              undef_o,
  input logic              undef_w
);

  logic [4:0] flag_vec;
  assign flag_vec = {pf_o, zf_o, sf_o, of_o, cf_o};

  assert_undef_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (upd_o == 5'b0));

  assert_undef_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == 2'b00 && cnt_i[4:0] > 5'd16) |=> undef_o);

  assert_flags_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_vec & ~upd_o) == 5'b0));

  assert_of_with_cf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o[1] |-> upd_o[0]);

  assert_zf_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o[3] |-> (zf_o == (res_o == '0)));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == 2'b01 && cnt_i[4:0] == 5'd0) |=>
      (res_o == {{(DATA_W-32){1'b0}}, $past(dst_i[31:0])} && upd_o == 5'b0));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == 2'b00) |=> (res_o[DATA_W-1:16] == '0));

  assert_registered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    undef_w |=> undef_o);

endmodule

bind funnel_shr_unit funnel_shr_checks #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .dst_i   (dst_i),
  .cnt_i   (cnt_i),
  .size_i  (size_i),
  .res_o   (res_o),
  .cf_o    (cf_o),
  .of_o    (of_o),
  .sf_o    (sf_o),
  .zf_o    (zf_o),
  .pf_o    (pf_o),
  .upd_o   (upd_o),
  .undef_o (undef_o),
  .undef_w (undef_w)
);

// File: tb/funnel_shr_unit_test.sv
module funnel_shr_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] res_o;
  logic        cf_o, of_o, sf_o, zf_o, pf_o, undef_o;
  logic [4:0]  upd_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  funnel_shr_unit uut (
    .clk(clk), .rst_n(rst_n), .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i),
    .size_i(size_i), .res_o(res_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o),
    .zf_o(zf_o), .pf_o(pf_o), .upd_o(upd_o), .undef_o(undef_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (size %0d cnt %h dst %h src %h)",
               tag, act, exp, size_i, cnt_i, dst_i, src_i);
    end
  endtask

  function automatic int width_of(input logic [1:0] sz);
    return (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
  endfunction

  // Bit-by-bit restatement of the shift and flag rules.
  task automatic model(input logic [1:0] sz, input logic [7:0] rc,
                       input logic [63:0] d, input logic [63:0] s,
                       output logic [63:0] r, output logic [4:0] fl,
                       output logic [4:0] up, output logic ud, output int c);
    int w;
    w = width_of(sz);
    c = (w == 64) ? int'(rc & 8'h3f) : int'(rc & 8'h1f);
    r = '0;
    for (int i = 0; i < w; i++) r[i] = d[i];
    fl = '0; up = '0; ud = 1'b0;
    if (c > w) begin
      ud = 1'b1;
    end else if (c != 0) begin
      for (int i = 0; i < w; i++)
        r[i] = (i < w - c) ? d[i + c] : s[i + c - w];
      fl[0] = d[c - 1];
      fl[1] = (c == 1) ? (r[w-1] ^ d[w-1]) : 1'b0;
      fl[2] = r[w-1];
      fl[3] = 1'b1;
      for (int i = 0; i < w; i++) if (r[i]) fl[3] = 1'b0;
      fl[4] = 1'b1;
      for (int i = 0; i < 8; i++) if (r[i]) fl[4] = ~fl[4];
      up = (c == 1) ? 5'b11111 : 5'b11101;
    end
  endtask

  task automatic apply(input logic [1:0] sz, input logic [7:0] rc,
                       input logic [63:0] d, input logic [63:0] s);
    logic [63:0] er;
    logic [4:0]  ef, eu;
    logic        eud;
    int          c, w;
    string       rtag;
    @(negedge clk);
    size_i = sz; cnt_i = rc; dst_i = d; src_i = s;
    model(sz, rc, d, s, er, ef, eu, eud, c);
    w = width_of(sz);
    if (eud)          rtag = "R8 result";
    else if (c == 0)  rtag = (rc != 8'h00) ? "R1 R4 masked-zero result" : "R4 result";
    else if (c == w)  rtag = "R10 result";
    else              rtag = "R3 result";
    @(negedge clk);
    chk(rtag, res_o, er);
    chk((c == w) ? "R10 R5 carry" : "R5 carry", 64'(cf_o), 64'(ef[0]));
    chk("R6 overflow", 64'(of_o), 64'(ef[1]));
    chk("R7 sign", 64'(sf_o), 64'(ef[2]));
    chk("R7 zero", 64'(zf_o), 64'(ef[3]));
    chk("R7 parity", 64'(pf_o), 64'(ef[4]));
    chk("R9 update enables", 64'(upd_o), 64'(eu));
    chk("R8 undefined", 64'(undef_o), 64'(eud));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    dst_i = 64'hFFFF_FFFF_FFFF_FFFF; src_i = 64'h1234_5678_9ABC_DEF0; cnt_i = 8'd3;
    size_i = 2'b10;
    repeat (3) @(negedge clk);
    chk("R2 reset result", res_o, 64'h0);
    chk("R2 reset flags", 64'({pf_o, zf_o, sf_o, of_o, cf_o, upd_o, undef_o}), 64'h0);
    rst_n = 1'b1;

    // Directed corners.
    apply(2'b00, 8'd0,  64'hFFFF_0000_0000_8001, 64'h5555);
    apply(2'b00, 8'd1,  64'h0000_0000_0000_8001, 64'h0000);
    apply(2'b00, 8'd16, 64'h0000_0000_0000_8000, 64'hABCD);
    apply(2'b00, 8'd17, 64'h1111_2222_3333_4444, 64'hFFFF);
    apply(2'b00, 8'd31, 64'h0000_0000_0000_7777, 64'h0001);
    apply(2'b00, 8'h21, 64'h0000_0000_0000_0003, 64'h8000);
    apply(2'b01, 8'h20, 64'hAAAA_AAAA_8765_4321, 64'h1);
    apply(2'b01, 8'd1,  64'h0000_0000_8000_0000, 64'h0);
    apply(2'b01, 8'd32, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0000);
    apply(2'b10, 8'h40, 64'hDEAD_BEEF_0000_0001, 64'h1);
    apply(2'b10, 8'd63, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    apply(2'b11, 8'd1,  64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001);
    apply(2'b10, 8'd8,  64'h0000_0000_0000_00FF, 64'h0);

    // Every raw count byte for every size code.
    for (int sz = 0; sz < 4; sz++)
      for (int rc = 0; rc < 256; rc++)
        apply(2'(sz), 8'(rc), {$urandom, $urandom}, {$urandom, $urandom});

    // Random operands, counts biased toward the interesting range.
    for (int n = 0; n < 1500; n++) begin
      logic [1:0] sz;
      logic [7:0] rc;
      sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) rc = 8'($urandom_range(0, 255));
      else rc = 8'($urandom_range(0, width_of(sz) + 1)) | 8'($urandom_range(0, 3) << 6);
      apply(sz, rc, {$urandom, $urandom}, ($urandom_range(0, 7) == 0) ? 64'h0 : {$urandom, $urandom});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule